// File: doc/BRIEF.md
# Burst-Mode ADC Acquisition Controller

This block is a host-side synchronous sequencer for an 8-bit multiplexed parallel-bus ADC that sits in power-down between measurements. A one-cycle trigger pulse wakes the converter by raising its active-low power-down line. The block then waits a programmed wake interval and runs a burst of conversions over a channel list captured at the trigger. Each result leaves on a valid/ready stream tagged with its channel code. When the burst is finished, the converter goes back into power-down.

Two access styles are supported. In write-read mode each conversion is a write strobe, a wait for the end-of-conversion interrupt, and a read strobe. In pipelined mode the write and read strobes fall together, so every access starts a new conversion and returns the previous one's result. Before any conversion starts, the controller enforces a settling time on the channel address and a gap after the interrupt. The first burst after reset adds a throw-away conversion. Every delay is a cycle count set by a parameter.

The result stream follows the usual rule: a word is transferred on a clock edge where `res_valid` and `res_ready` are both high. While `res_ready` is low, the word on offer is held unchanged. In that case the sequencer stalls before its next access and no result is dropped.

Top module: `burst_adc_seq`

## Requirements
- R1: After reset, `adc_pwr_n` is 0, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are 1, `res_valid` is 0 and `ovr_count` is 0.
- R2: A `trig` pulse while idle sets `adc_pwr_n` to 1. The first `adc_wr_n` fall of the burst comes at least PWRUP_CYC+REFSW_CYC cycles after that rise.
- R3: `adc_addr` does not change while `adc_cs_n` is 0. It has been unchanged for at least ACQ_CYC cycles at every `adc_wr_n` fall.
- R4: At least ACQ_CYC cycles pass between a fall of `adc_int_n` and the next fall of `adc_wr_n`.
- R5: With `cfg_pipe`=0, each conversion is a write strobe of WR_CYC+1 cycles with `adc_rd_n` high. The sequencer then waits for `adc_int_n` low, and a read strobe samples `adc_data`. Results appear in list order.
- R6: With `cfg_pipe`=1, `adc_rd_n` is low whenever `adc_wr_n` is low. The data read by an access is reported with the channel of the preceding access. One trailing access collects the last result, so a burst of N entries makes N+1 conversions.
- R7: The first burst after reset makes one extra conversion on list entry 0 before the list and never reports its result. Later bursts make no extra conversion.
- R8: Entry i of the list is `cfg_list[i*CH_W +: CH_W]`. Each result carries the 8 bits read (`res_data`), the channel code of its conversion (`res_chan`) and `res_first`=1 on the first result of a burst only. Code 7 reads the internal reference channel, full scale 8'hFF.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data`, `res_chan` and `res_first` hold their values, and no result is lost.
- R10: A burst yields exactly L results: L = `cfg_len` clipped to MAX_LEN, and a length of 0 is treated as 1.
- R11: A `trig` pulse during an active burst starts nothing and adds 1 to `ovr_count`, which saturates at its maximum.
- R12: After the last result of a burst is accepted into the output register, `adc_pwr_n` returns to 0. `adc_cs_n` is never 0 while `adc_pwr_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig | input | 1 | One-cycle burst start pulse |
| cfg_list | input | MAX_LEN*CH_W | Channel codes, entry i at bits i*CH_W |
| cfg_len | input | clog2(MAX_LEN+1)+1 | Requested burst length |
| cfg_pipe | input | 1 | 1 selects pipelined accesses |
| adc_pwr_n | output | 1 | Converter power-down, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_addr | output | CH_W | Multiplexer channel address |
| adc_int_n | input | 1 | End-of-conversion interrupt, active low |
| adc_data | input | 8 | Converter data bus |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 8 | Conversion result |
| res_chan | output | CH_W | Channel code of the result |
| res_first | output | 1 | First result of a burst |
| ovr_count | output | OVR_W | Saturating count of ignored triggers |

## Verification
A wrong access counter or discard rule shows up at the stream within one burst. The result count is off by one, the channel tags shift by one position, or the throw-away value 8'hA5 leaks out as the first result. A lost pipeline slot in the pipelined path makes the data lag the wrong channel, and this is visible on the very next result. A state machine that mis-times its timer becomes visible at the next write strobe. The bench measures the spacing from the power-up rise, from the interrupt fall and from the last address change to each write fall, and counts any strobe seen during power-down.

// File: rtl/burst_adc_pkg.sv
package burst_adc_pkg;
  typedef enum logic [2:0] {
    S_SLEEP, S_WAKE, S_SETUP, S_STROBE, S_WAITINT, S_READ, S_POST
  } seq_st_t;

  // cycles during which a stale interrupt level is ignored after an access
  localparam int INT_BLANK = 2;
endpackage

// File: rtl/burst_adc_timer.sv
module burst_adc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/burst_adc_chsel.sv
module burst_adc_chsel #(
  parameter int CH_W    = 3,
  parameter int MAX_LEN = 8,
  parameter int IDX_W   = 3
) (
  input  logic [MAX_LEN*CH_W-1:0] list,
  input  logic [IDX_W-1:0]        idx,
  output logic [CH_W-1:0]         ch
);
  logic [CH_W-1:0] ent [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_unpack
    assign ent[g] = list[g*CH_W +: CH_W];
  end

  always_comb begin
    ch = ent[0];
    for (int i = 0; i < MAX_LEN; i++) begin
      if (idx == IDX_W'(i)) ch = ent[i];
    end
  end
endmodule

// File: rtl/burst_adc_seq.sv
module burst_adc_seq
  import burst_adc_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int MAX_LEN   = 8,
  parameter int PWRUP_CYC = 90,
  parameter int REFSW_CYC = 0,
  parameter int ACQ_CYC   = 40,
  parameter int WR_CYC    = 63,
  parameter int RD_CYC    = 25,
  parameter int OVR_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig,
  input  logic [MAX_LEN*CH_W-1:0]      cfg_list,
  input  logic [$clog2(MAX_LEN+1):0]   cfg_len,
  input  logic                         cfg_pipe,
  output logic                         adc_pwr_n,
  output logic                         adc_cs_n,
  output logic                         adc_wr_n,
  output logic                         adc_rd_n,
  output logic [CH_W-1:0]              adc_addr,
  input  logic                         adc_int_n,
  input  logic [7:0]                   adc_data,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic [7:0]                   res_data,
  output logic [CH_W-1:0]              res_chan,
  output logic                         res_first,
  output logic [OVR_W-1:0]             ovr_count
);
  localparam int LEN_W   = $clog2(MAX_LEN+1) + 1;
  localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int K_W     = $clog2(MAX_LEN+3);
  localparam int WAKE_CYC = PWRUP_CYC + REFSW_CYC;
  localparam int TMAX1   = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
  localparam int TMAX2   = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int TMAX    = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW      = $clog2(TMAX+1) + 1;

  seq_st_t st, nxt;

  logic [MAX_LEN*CH_W-1:0] list_l;
  logic [LEN_W-1:0]        len_l, len_clip, emitted;
  logic                    pipe_l, primed;
  logic [K_W-1:0]          k;
  logic [IDX_W-1:0]        acc_idx;
  logic                    acc_real;
  logic [CH_W-1:0]         cur_chan;
  logic                    pend_real, cap_real;
  logic [CH_W-1:0]         pend_chan, cap_chan;
  logic [7:0]              cap_data;
  logic                    t_load, t_done;
  logic [TW-1:0]           t_val;
  logic                    emit, last_emit;

  // burst length clip, applied at trigger
  always_comb begin
    int lc;
    lc = int'(cfg_len);
    if (lc == 0)       lc = 1;
    if (lc > MAX_LEN)  lc = MAX_LEN;
    len_clip = LEN_W'(lc);
  end

  // access k -> list index; accesses before the list are throw-away
  always_comb begin
    int ji;
    ji = int'(k) - (primed ? 0 : 1);
    acc_real = (ji >= 0) && (ji < int'(len_l));
    if (ji < 0)                 acc_idx = '0;
    else if (ji >= int'(len_l)) acc_idx = IDX_W'(int'(len_l) - 1);
    else                        acc_idx = IDX_W'(ji);
  end

  burst_adc_chsel #(.CH_W(CH_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_chsel (
    .list (list_l),
    .idx  (acc_idx),
    .ch   (cur_chan)
  );

  assign emit      = (st == S_POST) && cap_real && (!res_valid || res_ready);
  assign last_emit = emit && ((emitted + 1'b1) == len_l);

  always_comb begin
    nxt = st;
    unique case (st)
      S_SLEEP:   if (trig) nxt = S_WAKE;
      S_WAKE:    if (t_done) nxt = S_SETUP;
      S_SETUP:   if (t_done) nxt = S_STROBE;
      S_STROBE:  if (t_done) nxt = S_WAITINT;
      S_WAITINT: if (t_done && !adc_int_n) nxt = pipe_l ? S_POST : S_READ;
      S_READ:    if (t_done) nxt = S_POST;
      S_POST: begin
        if (!cap_real)      nxt = S_SETUP;
        else if (last_emit) nxt = S_SLEEP;
        else if (emit)      nxt = S_SETUP;
      end
      default:   nxt = S_SLEEP;
    endcase
  end

  always_comb begin
    unique case (nxt)
      S_WAKE:    t_val = TW'(WAKE_CYC);
      S_SETUP:   t_val = TW'(ACQ_CYC);
      S_STROBE:  t_val = TW'(WR_CYC);
      S_WAITINT: t_val = TW'(INT_BLANK);
      S_READ:    t_val = TW'(RD_CYC);
      default:   t_val = '0;
    endcase
  end
  assign t_load = (nxt != st);

  burst_adc_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (t_load),
    .val   (t_val),
    .done  (t_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_SLEEP;
      list_l    <= '0;
      len_l     <= LEN_W'(1);
      pipe_l    <= 1'b0;
      primed    <= 1'b0;
      k         <= '0;
      emitted   <= '0;
      pend_real <= 1'b0;
      pend_chan <= '0;
      cap_real  <= 1'b0;
      cap_chan  <= '0;
      cap_data  <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      res_first <= 1'b0;
      ovr_count <= '0;
    end else begin
      st <= nxt;
      if (st == S_SLEEP && trig) begin
        list_l    <= cfg_list;
        len_l     <= len_clip;
        pipe_l    <= cfg_pipe;
        k         <= '0;
        emitted   <= '0;
        pend_real <= 1'b0;
      end
      if (trig && st != S_SLEEP && ovr_count != {OVR_W{1'b1}})
        ovr_count <= ovr_count + 1'b1;
      // pipelined: read returns the previous access's conversion
      if (st == S_STROBE && t_done && pipe_l) begin
        cap_data  <= adc_data;
        cap_real  <= pend_real;
        cap_chan  <= pend_chan;
        pend_real <= acc_real;
        pend_chan <= cur_chan;
      end
      if (st == S_READ && t_done) begin
        cap_data <= adc_data;
        cap_real <= acc_real;
        cap_chan <= cur_chan;
      end
      if (st == S_POST && nxt == S_SETUP) k <= k + 1'b1;
      if (st == S_POST && nxt == S_SLEEP) primed <= 1'b1;
      if (emit) begin
        res_valid <= 1'b1;
        res_data  <= cap_data;
        res_chan  <= cap_chan;
        res_first <= (emitted == '0);
        emitted   <= emitted + 1'b1;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign adc_pwr_n = (st != S_SLEEP);
  assign adc_wr_n  = !(st == S_STROBE);
  assign adc_rd_n  = !((st == S_STROBE && pipe_l) || st == S_READ);
  assign adc_cs_n  = !(st == S_STROBE || (!pipe_l && (st == S_WAITINT || st == S_READ)));
  assign adc_addr  = cur_chan;

  // R12
  sleep_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_pwr_n |-> adc_cs_n);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_addr));
  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) &&
                                    $stable(res_chan) && $stable(res_first)));
  // R6
  pipe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_wr_n && pipe_l) |-> !adc_rd_n);
  // R5
  wr_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_wr_n |-> !adc_cs_n);
  // R11
  ovr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_count >= $past(ovr_count));
  // R10
  emit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emitted <= len_l);
endmodule

// File: tb/burst_adc_seq_tb.sv
`timescale 1ns/1ps
module burst_adc_seq_tb;
  localparam int CH_W = 3, MAX_LEN = 8, PW = 90, RS = 8, ACQ = 40, WRC = 63, RDC = 25;
  localparam int CONV = 20;
  localparam int LW = $clog2(MAX_LEN+1) + 1;

  logic clk = 0, rst_n = 0, trig = 0, cfg_pipe = 0, res_ready;
  logic [MAX_LEN*CH_W-1:0] cfg_list = '0;
  logic [LW-1:0] cfg_len = '0;
  logic adc_pwr_n, adc_cs_n, adc_wr_n, adc_rd_n, res_valid, res_first;
  logic [CH_W-1:0] adc_addr, res_chan;
  logic [7:0] res_data, adc_data;
  logic [7:0] ovr_count;
  logic adc_int_n;

  always #2 clk = ~clk;

  burst_adc_seq #(.CH_W(CH_W), .MAX_LEN(MAX_LEN), .PWRUP_CYC(PW), .REFSW_CYC(RS),
    .ACQ_CYC(ACQ), .WR_CYC(WRC), .RD_CYC(RDC), .OVR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_list(cfg_list), .cfg_len(cfg_len),
    .cfg_pipe(cfg_pipe), .adc_pwr_n(adc_pwr_n), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
    .adc_rd_n(adc_rd_n), .adc_addr(adc_addr), .adc_int_n(adc_int_n), .adc_data(adc_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_chan(res_chan),
    .res_first(res_first), .ovr_count(ovr_count));

  int errors = 0, checks = 0;

  // ---------------- converter model ----------------
  logic m_wr_q, m_rd_q, m_busy, m_virgin;
  logic [CH_W-1:0] m_ch;
  logic [7:0] m_res;
  int m_cnt, conv_total;

  function automatic logic [7:0] code_of(input logic [CH_W-1:0] ch);
    return (ch == 3'd7) ? 8'hFF : (8'h30 + 8'(ch));
  endfunction

  assign adc_data = (!adc_cs_n && !adc_rd_n) ? m_res : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wr_q <= 1; m_rd_q <= 1; m_busy <= 0; m_virgin <= 1; m_ch <= '0;
      m_res <= 8'h00; m_cnt <= 0; adc_int_n <= 1; conv_total <= 0;
    end else begin
      m_wr_q <= adc_wr_n; m_rd_q <= adc_rd_n;
      if (!adc_cs_n && m_wr_q && !adc_wr_n) begin
        m_ch <= adc_addr; conv_total <= conv_total + 1;
      end
      if (!m_wr_q && adc_wr_n) begin
        m_busy <= 1; m_cnt <= CONV;
      end else if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy <= 0; adc_int_n <= 0;
          m_res <= m_virgin ? 8'hA5 : code_of(m_ch);
          m_virgin <= 0;
        end else m_cnt <= m_cnt - 1;
      end
      if (!m_rd_q && adc_rd_n) adc_int_n <= 1;
    end
  end

  // ---------------- monitors ----------------
  logic [CH_W-1:0] rc [0:15];
  logic [7:0] rdv [0:15];
  logic rf [0:15];
  int n_res = 0;
  bit bp_on = 0;
  int bp_cnt = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data; logic [CH_W-1:0] prev_chan;
  int bp_viol = 0, wake_viol = 0, acq_viol = 0, addr_viol = 0, sleep_viol = 0, pair_viol = 0;
  int wake_cnt = 0, int_age = 0, addr_age = 0;
  bit seen_wr = 0, int_seen = 0, p_wr = 1, p_int = 1;
  logic [CH_W-1:0] p_addr = '0;

  always @(negedge clk) begin
    res_ready = bp_on ? (bp_cnt % 5 == 0) : 1'b1;
    bp_cnt++;
    if (rst_n) begin
      if (res_valid && res_ready && n_res < 16) begin
        rc[n_res] = res_chan; rdv[n_res] = res_data; rf[n_res] = res_first; n_res++;
      end
      if (prev_stall && (!res_valid || res_data != prev_data || res_chan != prev_chan)) bp_viol++;
      prev_stall = res_valid && !res_ready; prev_data = res_data; prev_chan = res_chan;

      if (!adc_pwr_n) begin wake_cnt = 0; seen_wr = 0; int_seen = 0; end
      else wake_cnt++;
      if (!adc_pwr_n && !adc_cs_n) sleep_viol++;
      if (p_int && !adc_int_n) begin int_age = 0; int_seen = 1; end else int_age++;
      if (adc_addr != p_addr) begin
        if (!adc_cs_n) addr_viol++;
        addr_age = 0;
      end else addr_age++;
      if (p_wr && !adc_wr_n) begin
        if (!seen_wr && wake_cnt - 1 < PW + RS) wake_viol++;
        if (int_seen && int_age < ACQ) acq_viol++;
        if (addr_age < ACQ) addr_viol++;
        seen_wr = 1;
      end
      if (!adc_wr_n && (cfg_pipe ? adc_rd_n : !adc_rd_n)) pair_viol++;
      p_wr = adc_wr_n; p_int = adc_int_n; p_addr = adc_addr;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [MAX_LEN*CH_W-1:0] lst, input int len, input bit pipe,
                           input bit again, output int convs);
    int c0, t;
    @(negedge clk);
    cfg_list = lst; cfg_len = LW'(len); cfg_pipe = pipe; n_res = 0; c0 = conv_total;
    trig = 1; @(negedge clk); trig = 0;
    t = 0;
    while (!adc_pwr_n && t < 10) begin @(negedge clk); t++; end
    if (again) begin
      repeat (30) @(negedge clk);
      trig = 1; @(negedge clk); trig = 0;
    end
    t = 0;
    while (adc_pwr_n && t < 30000) begin @(negedge clk); t++; end
    chk(t < 30000, "R12", "burst end within bound", t, 30000);
    t = 0;
    while (res_valid && t < 100) begin @(negedge clk); t++; end
    convs = conv_total - c0;
  endtask

  task automatic cmp_results(input string req, input logic [MAX_LEN*CH_W-1:0] lst, input int exp_n);
    chk(n_res == exp_n, "R10", {req, " result count"}, n_res, exp_n);
    for (int i = 0; i < exp_n && i < n_res; i++) begin
      logic [CH_W-1:0] ch;
      ch = lst[i*CH_W +: CH_W];
      chk(rc[i] == ch, req, $sformatf("chan[%0d]", i), rc[i], ch);
      chk(rdv[i] == code_of(ch), "R8", $sformatf("data[%0d]", i), rdv[i], code_of(ch));
      chk(rf[i] == (i == 0), "R8", $sformatf("first[%0d]", i), rf[i], (i == 0));
    end
  endtask

  function automatic logic [MAX_LEN*CH_W-1:0] mk(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [MAX_LEN*CH_W-1:0] v;
    v = '0;
    v[0 +: 3] = 3'(a0); v[3 +: 3] = 3'(a1); v[6 +: 3] = 3'(a2); v[9 +: 3] = 3'(a3);
    v[12 +: 3] = 3'(a4); v[15 +: 3] = 3'(a5); v[18 +: 3] = 3'(a6); v[21 +: 3] = 3'(a7);
    return v;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(adc_pwr_n == 0, "R1", "pwr_n", adc_pwr_n, 0);
    chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1", "strobes idle", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    chk(res_valid == 0, "R1", "res_valid", res_valid, 0);
    chk(ovr_count == 0, "R1", "ovr_count", ovr_count, 0);
  endtask

  task automatic t_first_burst();  // R7 R5
    int cv;
    logic [MAX_LEN*CH_W-1:0] l;
    l = mk(2, 5, 1, 0, 0, 0, 0, 0);
    run_burst(l, 3, 0, 0, cv);
    cmp_results("R5", l, 3);
    chk(cv == 4, "R7", "conversions incl. discarded start-up", cv, 4);
    run_burst(l, 3, 0, 0, cv);
    cmp_results("R5", l, 3);
    chk(cv == 3, "R7", "no extra conversion once primed", cv, 3);
  endtask

  task automatic t_pipe();  // R6
    int cv;
    logic [MAX_LEN*CH_W-1:0] l;
    l = mk(3, 7, 0, 6, 0, 0, 0, 0);
    run_burst(l, 4, 1, 0, cv);
    cmp_results("R6", l, 4);
    chk(cv == 5, "R6", "pipelined conversions with trailing access", cv, 5);
  endtask

  task automatic t_clip();  // R10
    int cv;
    logic [MAX_LEN*CH_W-1:0] l;
    l = mk(0, 1, 2, 3, 4, 5, 6, 7);
    run_burst(l, 12, 0, 0, cv);
    cmp_results("R10", l, 8);
    l = mk(4, 1, 1, 1, 1, 1, 1, 1);
    run_burst(l, 0, 0, 0, cv);
    cmp_results("R10", l, 1);
  endtask

  task automatic t_backpressure();  // R9
    int cv;
    logic [MAX_LEN*CH_W-1:0] l;
    l = mk(1, 2, 3, 0, 0, 0, 0, 0);
    bp_on = 1;
    run_burst(l, 3, 1, 0, cv);
    repeat (20) @(negedge clk);
    bp_on = 0;
    cmp_results("R9", l, 3);
    chk(bp_viol == 0, "R9", "held output changed while stalled", bp_viol, 0);
  endtask

  task automatic t_overrun();  // R11
    int cv, o0;
    logic [MAX_LEN*CH_W-1:0] l;
    l = mk(6, 6, 0, 0, 0, 0, 0, 0);
    o0 = ovr_count;
    run_burst(l, 2, 0, 1, cv);
    cmp_results("R11", l, 2);
    chk(ovr_count == o0 + 1, "R11", "ovr_count step", ovr_count, o0 + 1);
    repeat (400) @(negedge clk);
    chk(adc_pwr_n == 0, "R11", "ignored trigger started no burst", adc_pwr_n, 0);
  endtask

  initial begin
    res_ready = 1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_first_burst();
    t_pipe();
    t_clip();
    t_backpressure();
    t_overrun();
    chk(wake_viol == 0, "R2", "wake wait too short", wake_viol, 0);
    chk(addr_viol == 0, "R3", "address settle/hold violations", addr_viol, 0);
    chk(acq_viol == 0, "R4", "acquisition gap violations", acq_viol, 0);
    chk(pair_viol == 0, "R6", "strobe pairing violations", pair_viol, 0);
    chk(sleep_viol == 0, "R12", "access while powered down", sleep_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule